// File: doc/BRIEF.md
# Buffered Handshake Channel

This block stands in for a one-cycle synchronous link between two parts of a design. It takes a stream in which each cycle either carries a data word (valid high) or carries nothing (valid low). Each word that arrives is stored in a small FIFO. A sending state machine then moves the words, one at a time, across an internal four-phase message handshake to a receiving state machine, which presents them on the output. Words are never reordered. A word is lost only when the buffer is full at the moment it arrives. A sticky overflow flag records any such loss.

On the input side, `in_ready` is status only and applies no back-pressure. The source may keep driving `in_valid`. A word offered while `in_ready` is low is dropped and raises `overflow`. On the output side, `out_ready` is back-pressure at transfer granularity. While it is low, the receiver does not start a new handshake and words wait in the buffer. A handshake that has already started still completes, and it delivers its word as a one-cycle `out_valid` pulse. Each delivered word carries `out_lat`, the number of clock edges from the edge that sampled it at the input to the edge that raised `out_valid`.

Top module: `hs_channel`

## Requirements
- R1: After synchronous active-high reset, `out_valid` is 0, `in_ready` is 1 and `overflow` is 0.
- R2: A cycle with `in_valid` low stores nothing, and no output word results from it whatever `in_data` holds.
- R3: Words leave in the order they were accepted, with their values unchanged. Every accepted word is delivered once `out_ready` is high long enough.
- R4: On an empty, idle channel with `out_ready` high, a word sampled at edge E raises `out_valid` at edge E+4.
- R5: `out_valid` is high for exactly one cycle per word. Two consecutive pulses are at least 6 edges apart, because each word takes a full four-phase exchange.
- R6: `in_ready` is low exactly while DEPTH words wait in the buffer. If `out_ready` is held low from idle, DEPTH+1 words are accepted, because one word waits in the sender.
- R7: A word offered while `in_ready` is low is dropped and sets `overflow` at the next edge. `overflow` stays set until `ovf_clr` is sampled high. A new drop in the same cycle as `ovf_clr` wins, so the flag stays set.
- R8: While `out_ready` is low, no new transfer starts. After three consecutive low cycles, `out_valid` stays low.
- R9: With `out_ready` high and at most 4 words in any 36-cycle window, no word is dropped and every `out_lat` is at most MAX_LAT (default DEPTH 8, MAX_LAT 64).
- R10: `out_lat` equals, modulo 2^LAT_W, the number of edges from the input sampling edge to the edge that raised `out_valid`. It is never below 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present this cycle |
| in_data | input | DATA_W | Input word |
| in_ready | output | 1 | Buffer has a free slot (low = full, offered word is dropped) |
| out_ready | input | 1 | Downstream permits new transfers |
| out_valid | output | 1 | One-cycle pulse, output word present |
| out_data | output | DATA_W | Output word, meaningful while out_valid is high |
| out_lat | output | LAT_W | Transport delay of the word on out_data, in cycles |
| overflow | output | 1 | Sticky flag: a word was dropped |
| ovf_clr | input | 1 | Synchronous clear of overflow |

## Verification
The assertions assume only that inputs are synchronous to `clk`. They do not assume a rate limit, so pulse spacing, flag stickiness, drop-on-full and the stall rule are checked under any traffic. The latency bound of R9 holds only under the 4-in-36 burst limit with `out_ready` high, so it is checked in a bench phase whose stimulus builds every 36-cycle window with exactly four randomly placed words. Other phases deliberately break that limit and toggle `out_ready` to exercise drops and stalls.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
  typedef enum logic [1:0] {
    SND_IDLE = 2'd0,
    SND_REQ  = 2'd1,
    SND_DATA = 2'd2
  } snd_state_e;

  typedef enum logic [1:0] {
    RCV_IDLE = 2'd0,
    RCV_RDY  = 2'd1,
    RCV_ACK  = 2'd2
  } rcv_state_e;

  // edges from input sampling to the out_valid edge on an idle channel
  localparam int unsigned HSC_MIN_LAT = 4;
endpackage

// File: rtl/hsc_fifo.sv
module hsc_fifo #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_wr, do_rd;

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= step_ptr(wp);
      if (do_rd) rp <= step_ptr(rp);
      unique case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end
endmodule

// File: rtl/hsc_sender.sv
module hsc_sender
  import hsc_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fifo_empty,
  input  logic [W-1:0] fifo_head,
  output logic         pop,
  output logic         req,
  input  logic         rdy,
  output logic         bus_valid,
  output logic [W-1:0] bus_data,
  input  logic         ack
);
  snd_state_e   st, st_n;
  logic [W-1:0] hold;

  always_comb begin
    st_n = st;
    pop  = 1'b0;
    unique case (st)
      SND_IDLE: if (!fifo_empty && !ack) begin
        pop  = 1'b1;
        st_n = SND_REQ;
      end
      SND_REQ:  if (rdy) st_n = SND_DATA;
      SND_DATA: if (ack) st_n = SND_IDLE;
      default:  st_n = SND_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= SND_IDLE;
    else     st <= st_n;
  end

  always_ff @(posedge clk) begin
    if (pop) hold <= fifo_head;
  end

  // data is placed on the bus only after the ready message
  assign req       = (st != SND_IDLE);
  assign bus_valid = (st == SND_DATA);
  assign bus_data  = bus_valid ? hold : '0;
endmodule

// File: rtl/hsc_receiver.sv
module hsc_receiver
  import hsc_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LAT_W  = 8,
  localparam int unsigned PW    = DATA_W + LAT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  output logic              rdy,
  input  logic              bus_valid,
  input  logic [PW-1:0]     bus_data,
  output logic              ack,
  input  logic [LAT_W-1:0]  now,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [LAT_W-1:0]  out_lat
);
  rcv_state_e st, st_n;
  logic       capture;

  assign capture = (st == RCV_RDY) && bus_valid;
  assign rdy     = (st == RCV_RDY);
  assign ack     = (st == RCV_ACK);

  always_comb begin
    st_n = st;
    unique case (st)
      RCV_IDLE: if (req && out_ready) st_n = RCV_RDY;
      RCV_RDY:  if (bus_valid)        st_n = RCV_ACK;
      RCV_ACK:  if (!bus_valid)       st_n = RCV_IDLE;
      default:  st_n = RCV_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= RCV_IDLE;
      out_valid <= 1'b0;
    end else begin
      st        <= st_n;
      out_valid <= capture;
    end
  end

  always_ff @(posedge clk) begin
    if (capture) begin
      out_data <= bus_data[DATA_W-1:0];
      out_lat  <= now - bus_data[PW-1:DATA_W];
    end
  end
endmodule

// File: rtl/hs_channel.sv
module hs_channel #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned MAX_LAT = 64,
  parameter int unsigned LAT_W   = $clog2(MAX_LAT) + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [LAT_W-1:0]  out_lat,
  output logic              overflow,
  input  logic              ovf_clr
);
  localparam int unsigned PW = DATA_W + LAT_W;

  logic [LAT_W-1:0] now_q;
  logic [PW-1:0]    head, bus;
  logic             f_empty, f_full, pop;
  logic             req, rdy, bus_valid, ack;

  // free-running time base used to stamp words for latency reporting
  always_ff @(posedge clk) begin
    if (rst) now_q <= '0;
    else     now_q <= now_q + 1'b1;
  end

  hsc_fifo #(.W(PW), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (in_valid),
    .wr_data ({now_q, in_data}),
    .rd_en   (pop),
    .rd_data (head),
    .empty   (f_empty),
    .full    (f_full)
  );

  hsc_sender #(.W(PW)) u_snd (
    .clk        (clk),
    .rst        (rst),
    .fifo_empty (f_empty),
    .fifo_head  (head),
    .pop        (pop),
    .req        (req),
    .rdy        (rdy),
    .bus_valid  (bus_valid),
    .bus_data   (bus),
    .ack        (ack)
  );

  hsc_receiver #(.DATA_W(DATA_W), .LAT_W(LAT_W)) u_rcv (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .rdy       (rdy),
    .bus_valid (bus_valid),
    .bus_data  (bus),
    .ack       (ack),
    .now       (now_q),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_lat   (out_lat)
  );

  assign in_ready = !f_full;

  // a drop in the same cycle as a clear keeps the flag set
  always_ff @(posedge clk) begin
    if (rst)                    overflow <= 1'b0;
    else if (in_valid && f_full) overflow <= 1'b1;
    else if (ovf_clr)           overflow <= 1'b0;
  end
endmodule

// File: rtl/hsc_checker.sv
module hsc_checker
  import hsc_pkg::*;
#(
  parameter int unsigned LAT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_ready,
  input logic             out_valid,
  input logic [LAT_W-1:0] out_lat,
  input logic             overflow,
  input logic             ovf_clr
);
  logic [1:0] stall_cnt;
  logic [2:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      stall_cnt <= '0;
      gap_cnt   <= 3'd7;
    end else begin
      stall_cnt <= out_ready ? 2'd0 : ((stall_cnt == 2'd3) ? 2'd3 : stall_cnt + 2'd1);
      gap_cnt   <= out_valid ? 3'd0 : ((gap_cnt == 3'd7) ? 3'd7 : gap_cnt + 3'd1);
    end
  end

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && in_ready && !overflow));

  a_r5_one_cycle_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  a_r5_pulse_spacing: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (gap_cnt >= 3'd5));

  a_r7_drop_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |=> overflow);

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (overflow && !ovf_clr) |=> overflow);

  a_r7_flag_clears: assert property (@(posedge clk) disable iff (rst)
    (ovf_clr && !(in_valid && !in_ready)) |=> !overflow);

  a_r8_no_output_when_stalled: assert property (@(posedge clk) disable iff (rst)
    (stall_cnt == 2'd3) |-> !out_valid);

  a_r10_latency_floor: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_lat >= LAT_W'(HSC_MIN_LAT)));
endmodule

bind hs_channel hsc_checker #(.LAT_W(LAT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .out_lat   (out_lat),
  .overflow  (overflow),
  .ovf_clr   (ovf_clr)
);

// File: tb/test_hs_channel.sv
module test_hs_channel;
  localparam int DW      = 8;
  localparam int DEPTH   = 8;
  localparam int MAX_LAT = 64;
  localparam int LW      = $clog2(MAX_LAT) + 2;
  localparam int MIN_LAT = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          out_ready = 1'b1;
  logic          ovf_clr = 1'b0;
  logic          in_ready, out_valid, overflow;
  logic [DW-1:0] out_data;
  logic [LW-1:0] out_lat;

  always #4 clk = ~clk;

  hs_channel #(.DATA_W(DW), .DEPTH(DEPTH), .MAX_LAT(MAX_LAT)) i_hs_channel (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_lat(out_lat), .overflow(overflow), .ovf_clr(ovf_clr)
  );

  int total = 0, bad = 0, cyc = 0;
  int n_out = 0, last_out_cyc = -100, prev_out_cyc = -100, max_lat = 0;
  logic [DW-1:0] q_d[$];
  int            q_c[$];
  bit            done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // one cycle of input; model records words the channel accepts
  task automatic drive(input bit v, input logic [DW-1:0] d);
    @(negedge clk);
    in_valid = v;
    in_data  = d;
    if (v && in_ready) begin
      q_d.push_back(d);
      q_c.push_back(cyc);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, DW'($urandom));
  endtask

  function automatic int expected_lat(input int out_cyc, input int in_cyc);
    return out_cyc - in_cyc - 1;
  endfunction

  // output monitor: R3 order/value, R10 latency report
  always @(negedge clk) begin
    logic [DW-1:0] ed;
    int            c, l;
    if (!rst && out_valid) begin
      n_out++;
      prev_out_cyc = last_out_cyc;
      last_out_cyc = cyc;
      if (q_d.size() == 0) begin
        check(1'b0, "R3 unexpected word", int'(out_data), -1);
      end else begin
        ed = q_d.pop_front();
        c  = q_c.pop_front();
        l  = expected_lat(cyc, c);
        check(out_data == ed, "R3 order/value", int'(out_data), int'(ed));
        check(out_lat == LW'(l), "R10 latency report", int'(out_lat), l);
        if (l > max_lat) max_lat = l;
      end
    end
  end

  initial begin
    #(8 * 150000);
    check(1'b0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    int base, acc, cd;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    check(overflow == 1'b0, "R1 overflow after reset", int'(overflow), 0);
    rst = 1'b0;
    idle(2);

    // R4: single word on idle channel
    drive(1'b1, 8'hA5);
    cd = cyc;
    idle(12);
    check(n_out == 1, "R4 single word delivered", n_out, 1);
    check(last_out_cyc - cd - 1 == MIN_LAT, "R4 idle latency", last_out_cyc - cd - 1, MIN_LAT);

    // R2: absent cycles with random data produce nothing
    base = n_out;
    idle(30);
    check(n_out == base, "R2 absent cycles silent", n_out, base);

    // R5: two back-to-back words are spaced by a full exchange
    drive(1'b1, 8'h11);
    drive(1'b1, 8'h22);
    idle(25);
    check(n_out == base + 2, "R5 both delivered", n_out, base + 2);
    check(last_out_cyc - prev_out_cyc == 6, "R5 pulse spacing", last_out_cyc - prev_out_cyc, 6);

    // R6/R7/R8: stall downstream and overfill
    base = n_out;
    acc  = 0;
    out_ready = 1'b0;
    for (int i = 0; i < DEPTH + 2; i++) begin
      @(negedge clk);
      if (in_ready) acc++;
      in_valid = 1'b1;
      in_data  = DW'(8'h30 + i);
      if (in_ready) begin
        q_d.push_back(in_data);
        q_c.push_back(cyc);
      end
    end
    drive(1'b0, '0);
    check(acc == DEPTH + 1, "R6 words accepted while stalled", acc, DEPTH + 1);
    check(in_ready == 1'b0, "R6 in_ready low when full", int'(in_ready), 0);
    check(overflow == 1'b1, "R7 overflow after drop", int'(overflow), 1);
    idle(20);
    check(n_out == base, "R8 no output while stalled", n_out, base);
    drive(1'b1, 8'hEE);
    ovf_clr = 1'b1;
    drive(1'b0, '0);
    check(overflow == 1'b1, "R7 drop wins over clear", int'(overflow), 1);
    drive(1'b0, '0);
    ovf_clr = 1'b0;
    check(overflow == 1'b0, "R7 clear", int'(overflow), 0);
    idle(5);
    check(overflow == 1'b0, "R7 stays clear", int'(overflow), 0);
    out_ready = 1'b1;
    idle(90);
    check(n_out == base + DEPTH + 1, "R3 drain after stall", n_out, base + DEPTH + 1);
    check(q_d.size() == 0, "R3 nothing left", q_d.size(), 0);

    // R9: burst-limited random traffic
    max_lat = 0;
    for (int w = 0; w < 40; w++) begin
      int need = 4;
      for (int s = 0; s < 36; s++) begin
        bit v = (need > 0) && ((need >= 36 - s) || ($urandom % 9 == 0));
        drive(v, DW'($urandom));
        if (v) need--;
      end
    end
    idle(90);
    check(overflow == 1'b0, "R9 no drop under burst limit", int'(overflow), 0);
    check(max_lat <= MAX_LAT, "R9 latency bound", max_lat, MAX_LAT);
    check(q_d.size() == 0, "R9 all delivered", q_d.size(), 0);

    // R3: unconstrained traffic with random back-pressure
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      out_ready = ($urandom % 4 != 0);
      in_valid  = ($urandom % 3 == 0);
      in_data   = DW'($urandom);
      if (in_valid && in_ready) begin
        q_d.push_back(in_data);
        q_c.push_back(cyc);
      end
    end
    out_ready = 1'b1;
    idle(120);
    check(q_d.size() == 0, "R3 random traffic drained", q_d.size(), 0);
    finish_run();
  end
endmodule